// File: doc/BRIEF.md
# Memory Array Summation Controller

This block adds up a fixed-length run of unsigned elements that sit in an external memory. A one-cycle start pulse tells it where the run begins through a base address. The block then walks the run one element at a time. For each element it forms the read address, issues a read, folds the returned word into a running total and steps its index. When every element has been consumed it raises done and presents the total on its result output.

The datapath is built around a single adder. Operand multiplexers in front of it pick one of three uses:
- the base address plus the index, to form the read address;
- the running total plus the zero-extended element, to accumulate;
- the index plus one, to step the loop.

The controller issues these uses in separate states, so the adder never serves two uses in the same cycle. The memory answers a read one cycle after the strobe, and the block waits for that answer before it accumulates.

Top module: `arr_sum_fsmd`

## Requirements
- R1: While reset is held and in the first cycle after it, done is 0, mem_rd is 0, result is 0 and mem_addr is 0.
- R2: A start accepted while idle or done clears the running total and the index before any read, so the result of a run never includes values from an earlier run.
- R3: Each run issues exactly LEN reads, at addresses base_addr + i for i = 0 to LEN-1 in increasing order, taken modulo 2^ADDR_W. No read is issued while done is 1.
- R4: mem_rd is a single-cycle strobe per element. The element is taken from mem_rdata in the cycle after the strobe cycle.
- R5: result equals the sum of the LEN elements, each zero-extended from DATA_W bits, modulo 2^ACC_W.
- R6: done first reads 1 exactly 2 + 5*LEN rising edges after the edge that accepted start. With the default LEN of 128 that is 642 edges.
- R7: Once done is 1 it stays 1, and result holds its value, until the next start. done drops in the cycle after a start is accepted from the done state.
- R8: A start pulse that arrives while a run is in progress has no effect: the run's reads, sum and latency are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a summation |
| base_addr | input | ADDR_W | First element address; held steady during a run |
| mem_addr | output | ADDR_W | Read address presented to the memory |
| mem_rd | output | 1 | Read strobe, one cycle per element |
| mem_rdata | input | DATA_W | Read data, valid the cycle after the strobe |
| done | output | 1 | Run finished; result is valid |
| result | output | ACC_W | Accumulated sum |

## Verification
The bench aims at these corner cases of the run and what a faulty design would show:
- A base address near the top of the address space forces the read addresses to wrap. A design that carried into a wider address, or stepped in the wrong order, would read the wrong words and produce a different sum.
- A memory filled with all-ones elements tells zero extension apart from sign extension. A sign-extending design would return a small negative total instead of 128 × 65535.
- Back-to-back runs over different data expose a total that was never cleared. Such a design would report a result that keeps growing across runs.
- A start pulse injected in the middle of a run would, if honoured, restart the loop. The run would then finish late and with a different read count.
- Capturing read data in the strobe cycle instead of one cycle later would shift every element by one position and corrupt the sum.

// File: rtl/arr_sum_pkg.sv
package arr_sum_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CLEAR = 3'd1,
        ST_TEST  = 3'd2,
        ST_ADDR  = 3'd3,
        ST_READ  = 3'd4,
        ST_ACCUM = 3'd5,
        ST_STEP  = 3'd6,
        ST_DONE  = 3'd7
    } ctl_state_e;

    typedef enum logic [1:0] {
        USE_NONE = 2'd0,
        USE_ADDR = 2'd1,
        USE_ACC  = 2'd2,
        USE_INC  = 2'd3
    } adder_use_e;

    typedef struct packed {
        adder_use_e use_sel;
        logic       clear;
        logic       load_addr;
        logic       load_acc;
        logic       load_idx;
        logic       rd;
        logic       fin;
    } ctl_cmd_t;

    function automatic int unsigned run_cycles(input int unsigned len);
        return 2 + 5 * len;
    endfunction

endpackage

// File: rtl/arr_sum_ctrl.sv
module arr_sum_ctrl
    import arr_sum_pkg::*;
#(
    parameter int LEN   = 128,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] idx,
    output ctl_cmd_t         cmd
);
    localparam logic [IDX_W-1:0] BOUND = IDX_W'(LEN);

    ctl_state_e state_q, state_d;
    logic       more;

    assign more = (idx < BOUND);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_CLEAR;
            ST_CLEAR: state_d = ST_TEST;
            ST_TEST:  state_d = more ? ST_ADDR : ST_DONE;
            ST_ADDR:  state_d = ST_READ;
            ST_READ:  state_d = ST_ACCUM;
            ST_ACCUM: state_d = ST_STEP;
            ST_STEP:  state_d = ST_TEST;
            ST_DONE:  if (start) state_d = ST_CLEAR;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        cmd = '{use_sel: USE_NONE, clear: 1'b0, load_addr: 1'b0,
                load_acc: 1'b0, load_idx: 1'b0, rd: 1'b0, fin: 1'b0};
        unique case (state_q)
            ST_CLEAR: cmd.clear = 1'b1;
            ST_ADDR: begin
                cmd.use_sel   = USE_ADDR;
                cmd.load_addr = 1'b1;
            end
            ST_READ:  cmd.rd = 1'b1;
            ST_ACCUM: begin
                cmd.use_sel  = USE_ACC;
                cmd.load_acc = 1'b1;
            end
            ST_STEP: begin
                cmd.use_sel  = USE_INC;
                cmd.load_idx = 1'b1;
            end
            ST_DONE:  cmd.fin = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/arr_sum_adder.sv
module arr_sum_adder
    import arr_sum_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int ACC_W  = 32,
    parameter int IDX_W  = 8
) (
    input  adder_use_e        use_sel,
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ACC_W-1:0]  acc,
    input  logic [DATA_W-1:0] elem,
    output logic [ACC_W-1:0]  sum
);
    logic [ACC_W-1:0] op_a, op_b;

    always_comb begin
        unique case (use_sel)
            USE_ADDR: begin
                op_a = ACC_W'(base);
                op_b = ACC_W'(idx);
            end
            USE_ACC: begin
                op_a = acc;
                op_b = ACC_W'(elem);
            end
            USE_INC: begin
                op_a = ACC_W'(idx);
                op_b = ACC_W'(1);
            end
            default: begin
                op_a = '0;
                op_b = '0;
            end
        endcase
    end

    assign sum = op_a + op_b;
endmodule

// File: rtl/arr_sum_regs.sv
module arr_sum_regs #(
    parameter int ADDR_W = 10,
    parameter int ACC_W  = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load_addr,
    input  logic              load_acc,
    input  logic              load_idx,
    input  logic [ACC_W-1:0]  sum,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ACC_W-1:0]  acc_q,
    output logic [IDX_W-1:0]  idx_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            acc_q  <= '0;
            idx_q  <= '0;
        end else begin
            if (clear) begin
                acc_q <= '0;
                idx_q <= '0;
            end
            if (load_addr) addr_q <= sum[ADDR_W-1:0];
            if (load_acc)  acc_q  <= sum;
            if (load_idx)  idx_q  <= sum[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/arr_sum_fsmd.sv
module arr_sum_fsmd
    import arr_sum_pkg::*;
#(
    parameter int LEN    = 128,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [ACC_W-1:0]  result
);
    localparam int IDX_W = $clog2(LEN + 1);

    ctl_cmd_t         cmd;
    logic [IDX_W-1:0] idx_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;

    arr_sum_ctrl #(.LEN(LEN), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .idx(idx_q), .cmd(cmd)
    );

    arr_sum_adder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_adder (
        .use_sel(cmd.use_sel), .base(base_addr), .idx(idx_q),
        .acc(acc_q), .elem(mem_rdata), .sum(sum)
    );

    arr_sum_regs #(.ADDR_W(ADDR_W), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst(rst), .clear(cmd.clear), .load_addr(cmd.load_addr),
        .load_acc(cmd.load_acc), .load_idx(cmd.load_idx), .sum(sum),
        .addr_q(mem_addr), .acc_q(acc_q), .idx_q(idx_q)
    );

    assign mem_rd = cmd.rd;
    assign done   = cmd.fin;
    assign result = acc_q;
endmodule

// File: rtl/arr_sum_chk.sv
module arr_sum_chk #(
    parameter int LEN    = 128,
    parameter int ADDR_W = 10,
    parameter int ACC_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [ADDR_W-1:0] base_addr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              done,
    input logic [ACC_W-1:0]  result
);
    localparam int CNT_W = $clog2(LEN + 1) + 1;

    logic [CNT_W-1:0] rd_cnt;

    always_ff @(posedge clk) begin
        if (rst || done) rd_cnt <= '0;
        else if (mem_rd) rd_cnt <= rd_cnt + 1'b1;
    end

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);  // R4

    AST_NO_RD_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_rd);  // R3

    AST_ADDR_ORDER: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (mem_addr == base_addr + ADDR_W'(rd_cnt)));  // R3

    AST_READ_COUNT: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (rd_cnt == CNT_W'(LEN)));  // R3

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(result)));  // R7

    AST_DONE_DROP: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> !done);  // R7
endmodule

bind arr_sum_fsmd arr_sum_chk #(.LEN(LEN), .ADDR_W(ADDR_W), .ACC_W(ACC_W)) u_chk (.*);

// File: tb/arr_sum_fsmd_test.sv
module arr_sum_fsmd_test;
    localparam int LEN    = 128;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 16;
    localparam int ACC_W  = 32;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LAT    = 2 + 5 * LEN;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rd;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              done;
    logic [ACC_W-1:0]  result;

    logic [DATA_W-1:0] mem [DEPTH];

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int rd_seen = 0;
    int addr_bad = 0;
    int rd_back = 0;
    logic prev_rd = 1'b0;

    always #2 clk = ~clk;

    arr_sum_fsmd #(.LEN(LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_W(ACC_W)) uut (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .done(done), .result(result)
    );

    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

    always @(negedge clk) begin
        if (mem_rd) begin
            if (mem_addr != ADDR_W'(base_addr + ADDR_W'(rd_seen))) addr_bad++;
            if (prev_rd) rd_back++;
            rd_seen++;
        end
        prev_rd = mem_rd;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [ACC_W-1:0] ref_sum(input logic [ADDR_W-1:0] b);
        logic [ACC_W-1:0] s = '0;
        for (int i = 0; i < LEN; i++)
            s = s + ACC_W'(mem[ADDR_W'(b + ADDR_W'(i))]);
        return s;
    endfunction

    task automatic run_once(input logic [ADDR_W-1:0] b, input int poke, input string tag);
        int lat;
        logic [ACC_W-1:0] exp;
        base_addr = b;
        exp = ref_sum(b);
        @(negedge clk);
        rd_seen = 0; addr_bad = 0; rd_back = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R7 done drops after start", done, 0);
        lat = 0;
        while (!done && lat < 5000) begin
            @(negedge clk);
            lat++;
            start = (lat == poke);
        end
        start = 1'b0;
        chk(lat == LAT, {"R6 latency ", tag}, lat, LAT);
        chk(result == exp, {"R5 R2 sum ", tag}, result, exp);
        chk(rd_seen == LEN, {"R3 read count ", tag}, rd_seen, LEN);
        chk(addr_bad == 0, {"R3 address order ", tag}, addr_bad, 0);
        chk(rd_back == 0, {"R4 single strobe ", tag}, rd_back, 0);
    endtask

    initial begin
        void'($urandom(32'd2417));
        for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'($urandom);
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && mem_rd == 1'b0, "R1 reset outputs", {done, mem_rd}, 0);
        chk(result == '0 && mem_addr == '0, "R1 reset result/addr", result, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && mem_rd == 1'b0 && result == '0, "R1 after reset", result, 0);

        run_once(ADDR_W'(37), -1, "random base 37");
        begin
            logic [ACC_W-1:0] held;
            held = result;
            repeat (20) @(negedge clk);
            chk(done == 1'b1, "R7 done held", done, 1);
            chk(result == held, "R7 result held", result, held);
        end
        run_once(ADDR_W'(300), -1, "R2 second run");
        run_once(ADDR_W'(1000), -1, "R3 wrap base");
        run_once(ADDR_W'(512), 100, "R8 mid-run start");
        run_once(ADDR_W'(5), 639, "R8 late start");

        for (int i = 0; i < DEPTH; i++) mem[i] = '1;
        run_once(ADDR_W'(200), -1, "R5 all ones");
        chk(result == ACC_W'(LEN * 65535), "R5 zero extension", result, LEN * 65535);

        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        run_once(ADDR_W'(900), -1, "R2 all zero");

        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'($urandom);
            run_once(ADDR_W'($urandom), -1, "random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule